// File: doc/BRIEF.md
# Filtered Edge Capture Unit

This block snapshots a free-running counter value at the moment a chosen transition appears on an asynchronous capture pin. The pin first passes through a two-stage synchronizer. An optional glitch filter can then be switched in. It lets its output follow the pin only after the pin has held one level for four successive clock samples. An edge detector of selectable polarity then loads the counter value into a capture register and raises a one-cycle event pulse, which neighbouring flag or interrupt logic can consume.

When the counter reuses the capture register as its period limit, the surrounding timer asserts a disable input. While that input is high, the pin has no effect and the register keeps its value. The counter itself, interrupt handling and any bus access to the register lie outside this block.

Top module: `capture_unit`

## Requirements
- R1: After reset the capture register reads zero and the event output is low.
- R2: With the polarity input at 1, a low-to-high pin transition loads the register with the counter value present at the third rising clock edge after the pin changes, and the event output is high for the cycle after that edge.
- R3: With the polarity input at 0, a high-to-low pin transition captures the counter with the same timing as R2.
- R4: A pin transition of the polarity not selected produces no event and leaves the register unchanged.
- R5: The event output is high for exactly one cycle per capture, and the register holds its value in every cycle without an event.
- R6: With the filter enabled, a capture happens four clock cycles later than without it, so the counter value is taken at the seventh rising edge after the pin change.
- R7: With the filter enabled, a pin pulse of three cycles causes no capture, and a pulse of four cycles causes one.
- R8: While the disable input is high, pin transitions cause no event and the register keeps its value. Releasing the disable input with the pin steady causes no event.
- R9: Turning the filter on while the pin sits at a level different from the reset level causes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| rise_sel_i | input | 1 | Polarity select: 1 rising, 0 falling |
| filt_en_i | input | 1 | Glitch filter enable |
| cap_off_i | input | 1 | Disable capture (register used as period limit) |
| count_i | input | 16 | Counter value to snapshot |
| cap_val_o | output | 16 | Capture register |
| cap_evt_o | output | 1 | One-cycle capture event |

## Verification
The pin is driven with single steps of each polarity under both polarity settings. This separates correct edge selection from capturing on any change. Narrow pulses of one, three and four cycles are applied with and without the filter. They show that the unfiltered path reacts to a one-cycle pulse, while the filtered path rejects anything shorter than four samples and accepts exactly four. Because the counter advances every cycle, each captured value pins down the latency in cycles, and this distinguishes the unfiltered delay from the filtered one. Changes to the filter enable and the disable input are made with the pin steady, to show that reconfiguration alone never produces an event.

// File: rtl/cap_pkg.sv
package cap_pkg;
  // Edge qualifier: current and previous level with polarity selection.
  function automatic logic edge_hit(input logic level, input logic prev, input logic rising);
    return rising ? (level & ~prev) : (~level & prev);
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic din_i,
  output logic dout_o
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] run_cnt;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      out_q   <= 1'b0;
    end else if (!en_i) begin
      // preload so that enabling never creates an edge
      run_cnt <= '0;
      out_q   <= din_i;
    end else if (din_i == out_q) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      run_cnt <= '0;
      out_q   <= din_i;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign dout_o = out_q;

  // R6 / R7: an enabled filter only moves to the value of its latest sample
  p_filter_follows_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (out_q != $past(out_q))) |-> (out_q == $past(din_i)));
endmodule

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             rise_sel_i,
  input  logic             filt_en_i,
  input  logic             cap_off_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_evt_o
);
  import cap_pkg::*;

  logic pin_sync;
  logic pin_filt;
  logic level;
  logic level_prev;
  logic edge_seen;
  logic take;

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  cap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .en_i(filt_en_i), .din_i(pin_sync), .dout_o(pin_filt)
  );

  assign level     = filt_en_i ? pin_filt : pin_sync;
  assign edge_seen = edge_hit(level, level_prev, rise_sel_i);
  assign take      = edge_seen & ~cap_off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_prev <= 1'b0;
      cap_val_o  <= '0;
      cap_evt_o  <= 1'b0;
    end else begin
      level_prev <= level;
      cap_evt_o  <= take;
      if (take) cap_val_o <= count_i;
    end
  end

  // R2 / R3: an event carries the counter value of the edge that loaded it
  p_value_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |-> (cap_val_o == $past(count_i)));
  // R5: single-cycle pulse
  p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |=> !cap_evt_o);
  // R5: register steady without an event
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt_o |-> $stable(cap_val_o));
  // R8: disabled capture never signals
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_off_i |=> !cap_evt_o);
  // R4: the level after an event agrees with the selected polarity
  p_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |-> (level_prev == $past(rise_sel_i)));
endmodule

// File: tb/capture_unit_test.sv
module capture_unit_test;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] val;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pin_i = 1'b0;
  logic         rise_sel_i = 1'b1;
  logic         filt_en_i = 1'b0;
  logic         cap_off_i = 1'b0;
  logic [W-1:0] count_i = '0;
  logic [W-1:0] cap_val_o;
  logic         cap_evt_o;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic [W-1:0] last_val = '0;
  bit mon_on = 1'b0;

  capture_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_sel_i(rise_sel_i),
    .filt_en_i(filt_en_i), .cap_off_i(cap_off_i), .count_i(count_i),
    .cap_val_o(cap_val_o), .cap_evt_o(cap_evt_o)
  );

  always #10 clk = ~clk;                 // 50 MHz
  always @(negedge clk) count_i <= count_i + 1'b1;

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: change the pin, predict the capture if one is due
  task automatic drive_pin(input logic v, input bit expect_cap, input string tag);
    exp_t e;
    @(negedge clk);
    pin_i = v;
    #1;
    if (expect_cap) begin
      e.val = count_i + (filt_en_i ? W'(6) : W'(2));
      e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_drained(input string tag);
    check(sb.size() == 0, tag, W'(sb.size()), '0);
  endtask

  task automatic expect_held(input logic [W-1:0] v, input string tag);
    check(cap_val_o == v, tag, cap_val_o, v);
  endtask

  // monitor: compare every event against the scoreboard; hold check otherwise
  always @(negedge clk) begin
    if (mon_on) begin
      if (cap_evt_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4/R8 unexpected event", cap_val_o, last_val);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(cap_val_o == e.val, e.tag, cap_val_o, e.val);
        end
        last_val = cap_val_o;
      end else begin
        check(cap_val_o == last_val, "R5 hold", cap_val_o, last_val);
      end
    end
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] snap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(cap_val_o == '0, "R1 reset value", cap_val_o, '0);
    check(cap_evt_o == 1'b0, "R1 reset event", W'(cap_evt_o), '0);
    mon_on = 1'b1;
    idle(4);

    // R2: rising edge unfiltered
    drive_pin(1'b1, 1'b1, "R2 rising capture");
    idle(8); expect_drained("R2 drained");
    // R4: falling ignored in rising mode
    snap = cap_val_o;
    drive_pin(1'b0, 1'b0, "R4");
    idle(8); expect_held(snap, "R4 falling ignored");

    // R3: falling mode
    rise_sel_i = 1'b0;
    idle(4);
    drive_pin(1'b1, 1'b0, "R4");
    idle(8); expect_held(snap, "R4 rising ignored");
    drive_pin(1'b0, 1'b1, "R3 falling capture");
    idle(8); expect_drained("R3 drained");
    // one-cycle pulse unfiltered still seen
    drive_pin(1'b1, 1'b0, "R3");
    drive_pin(1'b0, 1'b1, "R3 narrow pulse falling");
    idle(8); expect_drained("R3 narrow drained");

    // R6: filter on, rising
    rise_sel_i = 1'b1;
    filt_en_i = 1'b1;
    idle(6);
    drive_pin(1'b1, 1'b1, "R6 filtered rising capture");
    idle(12); expect_drained("R6 drained");
    drive_pin(1'b0, 1'b0, "R6");
    idle(12);

    // R7: 3-cycle pulse rejected, 4-cycle accepted
    snap = cap_val_o;
    drive_pin(1'b1, 1'b0, "R7");
    idle(2);
    drive_pin(1'b0, 1'b0, "R7");
    idle(12); expect_held(snap, "R7 three-cycle pulse rejected");
    drive_pin(1'b1, 1'b1, "R7 four-cycle pulse accepted");
    idle(3);
    drive_pin(1'b0, 1'b0, "R7");
    idle(12); expect_drained("R7 drained");

    // R9: enable filter while pin high
    filt_en_i = 1'b0;
    rise_sel_i = 1'b0;
    idle(4);
    drive_pin(1'b1, 1'b0, "R9");
    idle(8);
    snap = cap_val_o;
    filt_en_i = 1'b1;
    idle(10); expect_held(snap, "R9 no event on filter enable");
    drive_pin(1'b0, 1'b1, "R9 filtered falling after enable");
    idle(12); expect_drained("R9 drained");

    // R8: disabled capture
    filt_en_i = 1'b0;
    rise_sel_i = 1'b1;
    idle(4);
    cap_off_i = 1'b1;
    snap = cap_val_o;
    drive_pin(1'b1, 1'b0, "R8");
    idle(5);
    drive_pin(1'b0, 1'b0, "R8");
    idle(5);
    drive_pin(1'b1, 1'b0, "R8");
    idle(8); expect_held(snap, "R8 disabled keeps value");
    @(negedge clk); cap_off_i = 1'b0;
    idle(8); expect_held(snap, "R8 release quiet");
    drive_pin(1'b0, 1'b0, "R8");
    idle(6);
    drive_pin(1'b1, 1'b1, "R8 capture after release");
    idle(8); expect_drained("R8 drained");

    mon_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule